// File: doc/BRIEF.md
# Bit-Serial Adder with Carry Flip-Flop

This block adds two N-bit words using one single-bit full adder, reused over N clock cycles. A start pulse captures both operands into right-shifting registers. It also loads an incoming carry into a carry flip-flop. On each following cycle the lowest remaining bit pair is combined with the stored carry. The new carry goes back into the flip-flop, and the sum bit enters the top of a result register that shifts right. After N steps the result register holds the full N-bit sum, least significant bit at position 0.

The block trades throughput for area. One addition costs N cycles, and the arithmetic hardware is a single full adder. A one-cycle completion pulse marks the result. The sum and the carry-out then stay on the outputs until the next accepted start.

Top module: `serial_adder`

## Requirements
- R1: While reset is asserted and right after it, busy, done, sum and carry_out are all 0.
- R2: A start seen while idle makes busy 1 from the next cycle. Busy stays 1 for N cycles. Done is 1 for exactly one cycle, N cycles after the start edge, and busy is 0 in that cycle.
- R3: When done is 1, sum equals (op_a + op_b + carry_in) modulo 2^N, using the operand values captured at the accepted start.
- R4: When done is 1, carry_out equals bit N of op_a + op_b + carry_in.
- R5: The carry_in value captured at start is the carry into bit 0. A value of 1 adds one to the result.
- R6: A start raised while busy is ignored. The running addition keeps its operands, and done keeps its timing.
- R7: While idle and without a start, sum and carry_out hold their last values.
- R8: A start raised in the cycle where done is 1 is accepted, and a new addition begins.
- R9: Bits are processed least significant first. After k steps, the top k bits of sum hold the lowest k bits of the final result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an addition (accepted only while idle) |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Result register (partial while busy) |
| carry_out | output | 1 | Carry flip-flop; the final carry after done |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Busy is due one edge after the start edge, and done, sum and carry_out are due N edges after it. Done falls again one edge later. The bench drives inputs on falling edges and counts rising edges from the start edge. It samples each result on the falling edge that follows the edge where that result becomes due. Checks in mid-run read the upper sum bits after exactly k edges. Checks for ignored starts and for holding compare the outputs on the falling edges after the stimulus.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;
  typedef enum logic {
    SA_IDLE = 1'b0,
    SA_RUN  = 1'b1
  } sa_state_e;
endpackage

// File: rtl/bit_full_adder.sv
module bit_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic prop;

  always_comb begin
    prop = x ^ y;
    s    = prop ^ cin;
    cout = (x & y) | (prop & cin);
  end

  // R3
  always_comb begin
    fa_arith_chk: assert ({cout, s} == (2'(x) + 2'(y) + 2'(cin)));
  end
endmodule

// File: rtl/shift_reg_right.sv
module shift_reg_right #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {ser_in, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (load || shift)  q <= q_d;
  end
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import serial_add_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  sa_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d;

  always_comb begin
    load    = (state_q == SA_IDLE) && start;
    step    = (state_q == SA_RUN);
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load) begin
      state_d = SA_RUN;
      cnt_d   = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        state_d = SA_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SA_IDLE;
      cnt_q   <= '0;
      done_q_r <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q_r <= done_d;
    end
  end

  logic done_q_r;
  assign busy = (state_q == SA_RUN);
  assign done = done_q_r;

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         carry_in,
  output logic [N-1:0] sum,
  output logic         carry_out,
  output logic         busy,
  output logic         done
);
  logic         load, step;
  logic [N-1:0] a_q, b_q;
  logic         fa_s, fa_co;
  logic         carry_q, carry_d;

  sa_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  shift_reg_right #(.W(N)) u_a_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
    .load_val(op_a), .ser_in(1'b0), .q(a_q)
  );

  shift_reg_right #(.W(N)) u_b_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
    .load_val(op_b), .ser_in(1'b0), .q(b_q)
  );

  bit_full_adder u_fa (
    .x(a_q[0]), .y(b_q[0]), .cin(carry_q), .s(fa_s), .cout(fa_co)
  );

  shift_reg_right #(.W(N)) u_sum_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
    .load_val('0), .ser_in(fa_s), .q(sum)
  );

  always_comb begin
    carry_d = carry_q;
    if (load)      carry_d = carry_in;
    else if (step) carry_d = fa_co;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             carry_q <= 1'b0;
    else if (load || step)  carry_q <= carry_d;
  end

  assign carry_out = carry_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(carry_out)));

  // R5
  carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (carry_out == $past(carry_in)));
endmodule

// File: tb/serial_adder_tb.sv
module serial_adder_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [N-1:0] sum;
  logic         carry_out, busy, done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  serial_adder #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum(sum), .carry_out(carry_out),
    .busy(busy), .done(done)
  );

  // {a, b, cin}
  localparam int NV = 10;
  localparam logic [2*N:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0},
    {8'hFF, 8'hFF, 1'b1},
    {8'hFF, 8'h00, 1'b1},
    {8'hFF, 8'h01, 1'b0},
    {8'h5A, 8'hA5, 1'b0},
    {8'h5A, 8'hA5, 1'b1},
    {8'h80, 8'h80, 1'b0},
    {8'h3C, 8'h47, 1'b1},
    {8'h12, 8'hE9, 1'b0},
    {8'h00, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Start issued at next falling edge; returns at the falling edge after done rises.
  task automatic run_add(input logic [N-1:0] a, input logic [N-1:0] b, input logic ci,
                         input bit mid_start);
    logic [N:0] exp;
    exp = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci};
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {31'b0, busy}, 32'd1);
    for (int k = 1; k < N; k++) begin
      if (mid_start && k == 2) begin
        op_a = ~a; op_b = 8'h33; carry_in = ~ci; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk("R2 busy held", {31'b0, busy}, 32'd1);
      chk("R2 no early done", {31'b0, done}, 32'd0);
      if (k == N/2)
        chk("R9 lsb first partial", {24'b0, sum[N-1 -: N/2], 4'b0},
            {24'b0, exp[N/2-1:0], 4'b0});
    end
    @(negedge clk);
    chk("R2 done pulse", {30'b0, done, busy}, 32'd2);
    chk("R3 sum", {24'b0, sum}, {24'b0, exp[N-1:0]});
    chk("R4 carry_out", {31'b0, carry_out}, {31'b0, exp[N]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {22'b0, busy, done, carry_out, sum[6:0]}, 32'd0);
    chk("R1 reset sum msb", {31'b0, sum[7]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {21'b0, busy, done, carry_out, sum}, 32'd0);

    for (int i = 0; i < NV; i++)
      run_add(VEC[i][2*N:N+1], VEC[i][N:1], VEC[i][0], 1'b0);

    // R5: carry-in adds exactly one
    run_add(8'h0F, 8'h00, 1'b1, 1'b0);
    chk("R5 carry_in weight", {24'b0, sum}, 32'h10);

    // R7: results hold while idle
    repeat (3) @(negedge clk);
    chk("R7 hold sum", {23'b0, carry_out, sum}, {23'b0, 1'b0, 8'h10});
    chk("R7 done low", {31'b0, done}, 32'd0);

    // R6: start during run ignored
    run_add(8'hC8, 8'h64, 1'b0, 1'b1);
    @(negedge clk);
    chk("R6 no restart", {31'b0, busy}, 32'd0);

    // R8: start on the done cycle
    run_add(8'hF0, 8'h0F, 1'b1, 1'b0);
    op_a = 8'h81; op_b = 8'h7F; carry_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 accepted on done", {31'b0, busy}, 32'd1);
    repeat (N - 1) @(negedge clk);
    @(negedge clk);
    chk("R8 done", {31'b0, done}, 32'd1);
    chk("R8 result", {23'b0, carry_out, sum}, 32'h100);

    // R1: reset mid-run clears outputs
    @(negedge clk);
    op_a = 8'hAA; op_b = 8'h55; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {22'b0, busy, done, carry_out, sum[6:0]}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule